// File: doc/BRIEF.md
# Programmable Colour Matrix Converter

This block converts a stream of three-component pixels from one colour space to another by applying a programmable 3x3 matrix with a per-channel offset. A typical use is RGB to YCrCb and back. Each component is 12 bits wide. Each of the three output components has its own set of four programmable values: three multipliers and one offset. A 2-bit range setting is shared by all three channels and scales the whole matrix and the offsets up to reach gains above unity.

The datapath is a three-stage pipeline. It multiplies, sums, adds the offset, applies the range scale, rounds to the nearest code and saturates. A new pixel may enter on every clock cycle. The coefficient inputs are sampled together with each pixel, so software may rewrite them while earlier pixels are still in flight without corrupting them.

Top module: `csc_matrix`

## Requirements
- R1: Output component j (0, 1, 2) equals the sum over k of input component k times multiplier `mult_coef_i[j][k]`, divided by 4096, plus the offset of lane j, before scaling, rounding and clamping.
- R2: Multipliers are 13-bit two's-complement values and are read as value/4096. The range is -4096 to +4095, that is -1.0 to about +0.9998.
- R3: Offsets are 13-bit two's-complement values in output-code units. Each is added to its lane's scaled product sum before rounding and is scaled by the same range factor.
- R4: The range setting multiplies products and offsets by 1 for value 0, by 2 for value 1 and by 4 for value 2. Value 3 behaves exactly like value 2.
- R5: The result is rounded to the nearest integer, and an exact half rounds upward (floor of x + 0.5).
- R6: Each output component is clamped to 0..4095. Negative results give 0, and results above 4095 give 4095.
- R7: `out_valid_o` equals `in_valid_i` delayed by exactly 3 clock cycles. Back-to-back valid inputs give back-to-back valid outputs.
- R8: Each pixel is computed only with the multipliers, offsets and range setting present on the cycle it is accepted. Later changes to these inputs do not affect pixels already accepted.
- R9: After a synchronous active-low reset, `out_valid_o` is 0 and all output components are 0.
- R10: While `out_valid_o` is 0, `pix_o` keeps the value of the last valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Input pixel qualifier |
| pix_i | input | 3x12 | Input components, index 0..2 |
| mult_coef_i | input | 3x3x13 | Multiplier [output lane][input component], signed /4096 |
| offs_coef_i | input | 3x13 | Per-lane offset, signed output codes |
| range_mode_i | input | 2 | Shared scale: 0 gives x1, 1 gives x2, 2 and 3 give x4 |
| out_valid_o | output | 1 | Output pixel qualifier |
| pix_o | output | 3x12 | Converted, rounded and clamped components |

## Verification
The assertions assume that `in_valid_i` is held at a known 0 during reset. The delay check compares against three cycles of post-reset input history, and the hold check relies on the reset value of the output register. The saturation checks assume that the accumulator cannot wrap. That holds for every 13-bit coefficient pattern and any 12-bit pixel, so the stimulus sweeps the full signed coefficient range, including -4096 and +4095, and all four range values. The stimulus drives inputs only on falling edges, which keeps every sampled input stable around the active edge.

// File: rtl/csc_pkg.sv
// Package: shared types and helpers for the colour matrix converter.
// Assumes: range setting is two bits wide; value 3 is reserved.
package csc_pkg;

    typedef enum logic [1:0] {
        SCALE_X1  = 2'd0,
        SCALE_X2  = 2'd1,
        SCALE_X4  = 2'd2,
        SCALE_RSV = 2'd3
    } csc_scale_e;

    // Map the range setting to a left-shift amount; reserved acts as x4.
    function automatic logic [1:0] scale_shift(input logic [1:0] mode);
        case (csc_scale_e'(mode))
            SCALE_X1: scale_shift = 2'd0;
            SCALE_X2: scale_shift = 2'd1;
            default:  scale_shift = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/csc_lane.sv
// Module: one output lane of the matrix. Stage 1 registers the three
// products together with the lane offset and shift taken on the same
// cycle. Stage 2 sums them, adds the offset in fixed point and scales.
// Assumes: pixels are unsigned, coefficients and offset two's complement.
module csc_lane #(
    parameter int DATA_W = 12,
    parameter int COEF_W = 13,
    parameter int FRAC_W = 12,
    parameter int ACC_W  = DATA_W + COEF_W + 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ld1,
    input  logic                            ld2,
    input  logic [2:0][DATA_W-1:0]          pix,
    input  logic [2:0][COEF_W-1:0]          coef,
    input  logic [COEF_W-1:0]               offs,
    input  logic [1:0]                      shift,
    output logic signed [ACC_W-1:0]         acc_q
);
    localparam int PROD_W = DATA_W + 1 + COEF_W;

    logic signed [PROD_W-1:0] prod_q [3];
    logic signed [COEF_W-1:0] offs_q;
    logic [1:0]               shift_q;
    logic signed [ACC_W-1:0]  sum_c;

    // Stage 1: capture products and the matching offset/shift snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) prod_q[k] <= '0;
            offs_q  <= '0;
            shift_q <= '0;
        end else if (ld1) begin
            for (int k = 0; k < 3; k++)
                prod_q[k] <= $signed({1'b0, pix[k]}) * $signed(coef[k]);
            offs_q  <= $signed(offs);
            shift_q <= shift;
        end
    end

    // Sum the products and the offset placed at the binary point.
    always_comb begin
        sum_c = ACC_W'(prod_q[0]) + ACC_W'(prod_q[1]) + ACC_W'(prod_q[2])
              + (ACC_W'(offs_q) <<< FRAC_W);
    end

    // Stage 2: apply the range scale and hold the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else if (ld2) acc_q <= sum_c <<< shift_q;
    end

endmodule

// File: rtl/csc_sat.sv
// Module: rounds a fixed-point accumulator to the nearest code (half up)
// and clamps it to the unsigned output range, then registers it.
// Assumes: the accumulator has FRAC_W fractional bits and cannot wrap.
module csc_sat #(
    parameter int DATA_W = 12,
    parameter int FRAC_W = 12,
    parameter int ACC_W  = 30
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld,
    input  logic signed [ACC_W-1:0]  acc,
    output logic [DATA_W-1:0]        pix_q
);
    localparam int RW = ACC_W + 1;
    localparam logic signed [RW-1:0] HALF  = RW'(1) <<< (FRAC_W - 1);
    localparam logic signed [RW-1:0] MAXV  = RW'((1 << DATA_W) - 1);

    logic signed [RW-1:0] rnd_c;
    logic [DATA_W-1:0]    sat_c;

    // Round half up, then clamp to 0..2^DATA_W-1.
    always_comb begin
        rnd_c = (RW'(acc) + HALF) >>> FRAC_W;
        if (rnd_c < 0)          sat_c = '0;
        else if (rnd_c > MAXV)  sat_c = '1;
        else                    sat_c = rnd_c[DATA_W-1:0];
    end

    // Output register: loads only for valid pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_q <= '0;
        else if (ld) pix_q <= sat_c;
    end

    // R6
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && acc < 0) |=> (pix_q == '0));

    // R6
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && acc >= ((ACC_W'((1 << DATA_W) - 1) <<< FRAC_W) + ACC_W'(HALF)))
        |=> (pix_q == '1));

endmodule

// File: rtl/csc_matrix.sv
// Module: top of the programmable 3x3 colour matrix with offsets.
// Three lanes compute in parallel; the valid flag follows a 3-stage delay.
// Assumes: coefficient inputs are sampled with each accepted pixel.
module csc_matrix #(
    parameter int DATA_W = 12,
    parameter int COEF_W = 13,
    parameter int FRAC_W = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid_i,
    input  logic [2:0][DATA_W-1:0]          pix_i,
    input  logic [2:0][2:0][COEF_W-1:0]     mult_coef_i,
    input  logic [2:0][COEF_W-1:0]          offs_coef_i,
    input  logic [1:0]                      range_mode_i,
    output logic                            out_valid_o,
    output logic [2:0][DATA_W-1:0]          pix_o
);
    import csc_pkg::*;

    localparam int ACC_W = DATA_W + COEF_W + 5;

    logic       v1_q, v2_q;
    logic [1:0] shift_c;
    logic [1:0] age_q;

    assign shift_c = scale_shift(range_mode_i);

    // Valid pipeline: stage flags matching the datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q        <= 1'b0;
            v2_q        <= 1'b0;
            out_valid_o <= 1'b0;
        end else begin
            v1_q        <= in_valid_i;
            v2_q        <= v1_q;
            out_valid_o <= v2_q;
        end
    end

    // Cycles since reset, saturating, used only to qualify the delay check.
    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    for (genvar j = 0; j < 3; j++) begin : g_lane
        logic signed [ACC_W-1:0] acc;

        csc_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .ld1   (in_valid_i),
            .ld2   (v1_q),
            .pix   (pix_i),
            .coef  (mult_coef_i[j]),
            .offs  (offs_coef_i[j]),
            .shift (shift_c),
            .acc_q (acc)
        );

        csc_sat #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_sat (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (v2_q),
            .acc   (acc),
            .pix_q (pix_o[j])
        );
    end

    // R7
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3)));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v2_q |=> ($stable(pix_o) && !out_valid_o));

endmodule

// File: tb/tb_csc_matrix.sv
module tb_csc_matrix;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid_i = 1'b0;
    logic [2:0][11:0] pix_i = '0;
    logic [2:0][2:0][12:0] mult_coef_i = '0;
    logic [2:0][12:0] offs_coef_i = '0;
    logic [1:0] range_mode_i = '0;
    logic out_valid_o;
    logic [2:0][11:0] pix_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit vh0 = 0, vh1 = 0, vh2 = 0;
    logic [35:0] exp_q[$];
    string tag_q[$];
    logic [2:0][11:0] last_out = '0;

    // stimulus shadow registers set by the phases
    logic [2:0][11:0] px = '0;
    logic [2:0][2:0][12:0] mc = '0;
    logic [2:0][12:0] oc = '0;
    logic [1:0] md = '0;

    always #4 clk = ~clk;

    csc_matrix dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, cycles %0d expected < 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [11:0] model(int j);
        longint acc = 0;
        longint r;
        int sh;
        for (int k = 0; k < 3; k++)
            acc += longint'(px[k]) * longint'($signed(mc[j][k]));
        acc += longint'($signed(oc[j])) * 4096;
        sh = (md == 2'd0) ? 0 : (md == 2'd1) ? 1 : 2;
        acc = acc <<< sh;
        r = (acc + 2048) >>> 12;
        if (r < 0) r = 0;
        if (r > 4095) r = 4095;
        return 12'(r);
    endfunction

    task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: check outputs at the falling edge, then drive the next input.
    task automatic step(bit v, string tag);
        logic [35:0] e;
        string t;
        @(negedge clk);
        check("R7 valid", 12'(out_valid_o), 12'(vh2));
        if (out_valid_o) begin
            if (exp_q.size() == 0) begin
                check("R7 spurious", 12'(1), 12'(0));
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                for (int j = 0; j < 3; j++) check(t, pix_o[j], e[12*j +: 12]);
            end
            last_out = pix_o;
        end else begin
            // R10: output holds while idle
            for (int j = 0; j < 3; j++) check("R10 hold", pix_o[j], last_out[j]);
        end
        in_valid_i   = v;
        pix_i        = px;
        mult_coef_i  = mc;
        offs_coef_i  = oc;
        range_mode_i = md;
        if (v) begin
            for (int j = 0; j < 3; j++) e[12*j +: 12] = model(j);
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        vh2 = vh1; vh1 = vh0; vh0 = v;
    endtask

    function automatic logic [12:0] rc();
        return 13'($urandom_range(0, 8191));
    endfunction

    initial begin
        logic [12:0] edges [5] = '{13'h1000, 13'h0FFF, 13'h0000, 13'h1FFF, 13'h0001};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 valid", 12'(out_valid_o), 12'(0));
        for (int j = 0; j < 3; j++) check("R9 pix", pix_o[j], 12'(0));

        // R1: random matrices, offsets and modes, with bubbles
        for (int i = 0; i < 600; i++) begin
            for (int j = 0; j < 3; j++) begin
                px[j] = 12'($urandom_range(0, 4095));
                oc[j] = 13'($signed($urandom_range(0, 255)) - 128);
                for (int k = 0; k < 3; k++) mc[j][k] = rc();
            end
            md = 2'($urandom_range(0, 3));
            step(($urandom_range(0, 3) != 0), "R1 matrix");
        end

        // R2: coefficient extremes per position with full-scale pixels
        for (int p = 0; p < 9; p++)
            for (int a = 0; a < 5; a++)
                for (int x = 0; x < 4; x++) begin
                    mc = '0; oc = '{13'd2048, 13'd2048, 13'd2048};
                    mc[p/3][p%3] = edges[a];
                    md = 2'd0;
                    px = '{12'(x * 1365), 12'(4095 - x * 1365), 12'(x * 1000)};
                    step(1'b1, "R2 coef range");
                end

        // R4: each range value, including the reserved one
        for (int m = 0; m < 4; m++)
            for (int x = 0; x < 128; x++) begin
                md = 2'(m);
                mc = '{'{13'd700, 13'd300, 13'h1F00}, '{13'h1E00, 13'd900, 13'd100}, '{13'd1200, 13'd1200, 13'd1200}};
                oc = '{13'd5, 13'h1FF0, 13'd64};
                px = '{12'(x * 32), 12'(4095 - x * 32), 12'(x * 17)};
                step(1'b1, "R4 range mode");
            end

        // R3: offsets alone across the signed range, all modes
        for (int m = 0; m < 3; m++)
            for (int o = -4096; o < 4096; o += 41) begin
                md = 2'(m); mc = '0;
                oc = '{13'(o), 13'(-o), 13'(o / 3)};
                px = '{12'd4095, 12'd1, 12'd77};
                step(1'b1, "R3 offset");
            end

        // R5: coefficient 0.5 on component 0 gives exact halves for odd inputs
        for (int x = 0; x < 4096; x++) begin
            md = 2'd0; mc = '0; oc = '0;
            mc[0][0] = 13'd2048; mc[1][0] = 13'd1024; mc[2][1] = 13'h1800;
            oc[2] = 13'd4095;
            px = '{12'(x), 12'(x), 12'(x)};
            step(x % 2 == 0 || x % 3 == 0, "R5 rounding");
        end

        // R6: drive into both clamps
        for (int i = 0; i < 200; i++) begin
            md = 2'($urandom_range(0, 3));
            for (int j = 0; j < 3; j++) begin
                px[j] = 12'($urandom_range(3000, 4095));
                oc[j] = (i % 2) ? 13'h0FFF : 13'h1000;
                for (int k = 0; k < 3; k++) mc[j][k] = (i % 2) ? 13'h0FFF : 13'h1000;
            end
            step(1'b1, "R6 clamp");
        end

        // R8: coefficients change every cycle, also during bubbles
        for (int i = 0; i < 600; i++) begin
            for (int j = 0; j < 3; j++) begin
                px[j] = 12'($urandom_range(0, 4095));
                oc[j] = rc();
                for (int k = 0; k < 3; k++) mc[j][k] = rc();
            end
            md = 2'($urandom_range(0, 3));
            step((i % 7) != 3, "R8 coef snapshot");
        end

        // drain
        for (int i = 0; i < 6; i++) step(1'b0, "drain");
        check("R7 queue empty", 12'(exp_q.size()), 12'(0));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule